// File: doc/BRIEF.md
# Sensor-Priority Junction Light Controller

This block drives the lamps of a two-road junction: a main road that rests on green and a side road that gets green only on demand. A single clock drives a four-phase sequencer and one shared phase timer. The timer restarts at zero each time the phase changes and advances by one every clock. The phases always follow the same cycle: main green, main yellow, side green, side yellow, then main green again.

Main green has no fixed end. A vehicle sensor on the side road ends it, but only once main green has been lit for a minimum hold. A sensor signal that arrives earlier and goes away again before the hold runs out is ignored. If no vehicle ever arrives, main green stays lit. Main green also has a nominal duration parameter, which sets how far the timer counts during main green. The other three phases end purely on time. Every duration is a parameter in clock cycles. The defaults match a 100 MHz clock (1 s nominal main green, 300 ms minimum hold, 200 ms for each yellow, 500 ms side green), and a bench can shrink them.

Top module: `tlc_junction_ctrl`

## Requirements
- R1: Reset is synchronous and active low. Any rising clock edge that samples `rst_n` low puts the controller in main green with the phase timer at zero, from any phase. The timing of the following main green then starts from that edge.
- R2: The phase code on `phase` is 0 for main green, 1 for main yellow, 2 for side green and 3 for side yellow. Phases are only ever entered in the cyclic order 0, 1, 2, 3, 0.
- R3: Main yellow lasts exactly MAIN_YEL_CYC clock cycles and side yellow lasts exactly SIDE_YEL_CYC clock cycles, whatever the sensor does.
- R4: Side green lasts exactly SIDE_GREEN_CYC clock cycles, whether the sensor is high or low.
- R5: During the first MIN_HOLD_CYC-1 cycles of main green, a high `side_sensor` has no effect. A sensor pulse that falls before the hold expires leaves the controller in main green.
- R6: At a rising edge during main green, if the sensor is sampled high and main green has already been lit for at least MIN_HOLD_CYC cycles (counting the cycle that ends at that edge), the phase changes to main yellow at that same edge. With the sensor high from entry, main green therefore lasts exactly MIN_HOLD_CYC cycles.
- R7: While the sensor stays low, main green persists indefinitely, including past MAIN_GREEN_CYC cycles.
- R8: Each lamp bus is one-hot: bit 0 is red, bit 1 is yellow and bit 2 is green. In phases 0 and 1, `side_lamp` shows red and `main_lamp` shows green (phase 0) or yellow (phase 1). In phases 2 and 3, `main_lamp` shows red and `side_lamp` shows green (phase 2) or yellow (phase 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| side_sensor | input | 1 | Side-road vehicle present, sampled every rising edge |
| main_lamp | output | 3 | Main-road lamp drive, one-hot {green, yellow, red} |
| side_lamp | output | 3 | Side-road lamp drive, one-hot {green, yellow, red} |
| phase | output | 2 | Current phase code (0..3 as in R2) |

## Verification
Two events can fall on the same clock edge: the minimum hold on main green running out, and a side-road sensor request. The bench provokes this by holding the sensor low for MIN_HOLD_CYC-1 edges after reset and raising it just before the next edge; the change to main yellow must happen at exactly that edge. A second run raises the sensor one edge earlier, and the phase must stay main green for one more edge and change only on the edge after that. The bench also confirms that a request which arrives and then drops inside the hold window leaves main green untouched. A request made long after the hold expires must take effect on its first sampled edge.

// File: rtl/tlc_pkg.sv
// Package: shared phase encoding and lamp bit positions for the
// junction light controller. Assumes two roads and four phases.
package tlc_pkg;

    typedef enum logic [1:0] {
        PH_MAIN_GO   = 2'd0,
        PH_MAIN_WARN = 2'd1,
        PH_SIDE_GO   = 2'd2,
        PH_SIDE_WARN = 2'd3
    } phase_e;

    localparam int LAMP_W   = 3;
    localparam int LAMP_RED = 0;
    localparam int LAMP_YEL = 1;
    localparam int LAMP_GRN = 2;
    localparam int NUM_ROADS = 2;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tlc_phase_timer.sv
// Module: phase timer. Counts clocks spent in the current phase.
// Clears to zero on reset or when the sequencer signals a phase change,
// and holds at SAT_VAL so that an indefinitely long main green cannot wrap.
// Assumes SAT_VAL fits in CNT_W bits.
module tlc_phase_timer #(
    parameter int CNT_W   = 8,
    parameter int SAT_VAL = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] SAT_Q = CNT_W'(SAT_VAL);

    // Purpose: restart on reset or phase change, else count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (count != SAT_Q) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/tlc_phase_sequencer.sv
// Module: phase sequencer. Holds the current phase and decides when to
// advance. Main green ends only on sensor demand after the minimum hold;
// the other phases end when the timer reaches their last cycle.
// Assumes every duration is at least 1 and the timer is cleared on advance.
module tlc_phase_sequencer
    import tlc_pkg::*;
#(
    parameter int CNT_W          = 8,
    parameter int MIN_HOLD_CYC   = 6,
    parameter int MAIN_YEL_CYC   = 3,
    parameter int SIDE_GREEN_CYC = 8,
    parameter int SIDE_YEL_CYC   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             side_sensor,
    input  logic [CNT_W-1:0] timer,
    output phase_e           phase_q,
    output logic             advance
);

    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(MIN_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] MY_LAST   = CNT_W'(MAIN_YEL_CYC - 1);
    localparam logic [CNT_W-1:0] SG_LAST   = CNT_W'(SIDE_GREEN_CYC - 1);
    localparam logic [CNT_W-1:0] SY_LAST   = CNT_W'(SIDE_YEL_CYC - 1);

    phase_e phase_d;

    // Purpose: choose the next phase from the current one, timer and sensor.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_MAIN_GO:   if (side_sensor && (timer >= HOLD_LAST)) phase_d = PH_MAIN_WARN;
            PH_MAIN_WARN: if (timer == MY_LAST) phase_d = PH_SIDE_GO;
            PH_SIDE_GO:   if (timer == SG_LAST) phase_d = PH_SIDE_WARN;
            PH_SIDE_WARN: if (timer == SY_LAST) phase_d = PH_MAIN_GO;
            default:      phase_d = PH_MAIN_GO;
        endcase
    end

    assign advance = (phase_d != phase_q);

    // Purpose: phase register, returning to main green on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_MAIN_GO;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/tlc_lamp_driver.sv
// Module: lamp driver. Decodes the phase into one one-hot lamp bus per road.
// Road 0 (main) owns phases 0 and 1, road 1 (side) owns phases 2 and 3;
// a road that does not own the phase shows red. Purely combinational.
module tlc_lamp_driver
    import tlc_pkg::*;
(
    input  phase_e                    phase,
    output logic [NUM_ROADS*LAMP_W-1:0] lamps
);

    for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
        logic owned;
        logic [LAMP_W-1:0] lamp;

        // Purpose: pick red, yellow or green for this road.
        always_comb begin
            owned = (phase[1] == r[0]);
            lamp  = '0;
            if (!owned) begin
                lamp[LAMP_RED] = 1'b1;
            end else if (phase[0]) begin
                lamp[LAMP_YEL] = 1'b1;
            end else begin
                lamp[LAMP_GRN] = 1'b1;
            end
        end

        assign lamps[r*LAMP_W +: LAMP_W] = lamp;
    end

endmodule

// File: rtl/tlc_junction_ctrl.sv
// Module: junction light controller top. Connects the phase timer, the
// phase sequencer and the lamp driver. Durations are in clock cycles;
// defaults assume a 100 MHz clock. Assumes MIN_HOLD_CYC <= MAIN_GREEN_CYC.
module tlc_junction_ctrl
    import tlc_pkg::*;
#(
    parameter int MAIN_GREEN_CYC = 100_000_000,
    parameter int MIN_HOLD_CYC   = 30_000_000,
    parameter int MAIN_YEL_CYC   = 20_000_000,
    parameter int SIDE_GREEN_CYC = 50_000_000,
    parameter int SIDE_YEL_CYC   = 20_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       side_sensor,
    output logic [2:0] main_lamp,
    output logic [2:0] side_lamp,
    output logic [1:0] phase
);

    localparam int MAX_CYC = max2(max2(MAIN_GREEN_CYC, MIN_HOLD_CYC),
                                  max2(max2(MAIN_YEL_CYC, SIDE_GREEN_CYC), SIDE_YEL_CYC));
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    logic [TMR_W-1:0]              timer_q;
    logic                          advance;
    phase_e                        phase_q;
    logic [NUM_ROADS*LAMP_W-1:0]   lamps;

    tlc_phase_timer #(
        .CNT_W   (TMR_W),
        .SAT_VAL (MAX_CYC - 1)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (advance),
        .count (timer_q)
    );

    tlc_phase_sequencer #(
        .CNT_W          (TMR_W),
        .MIN_HOLD_CYC   (MIN_HOLD_CYC),
        .MAIN_YEL_CYC   (MAIN_YEL_CYC),
        .SIDE_GREEN_CYC (SIDE_GREEN_CYC),
        .SIDE_YEL_CYC   (SIDE_YEL_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .side_sensor (side_sensor),
        .timer       (timer_q),
        .phase_q     (phase_q),
        .advance     (advance)
    );

    tlc_lamp_driver u_lamps (
        .phase (phase_q),
        .lamps (lamps)
    );

    assign main_lamp = lamps[0 +: LAMP_W];
    assign side_lamp = lamps[LAMP_W +: LAMP_W];
    assign phase     = phase_q;

endmodule

// File: rtl/tlc_junction_checker.sv
// Module: property checker for the junction controller, bound to the top.
// Observes the phase, the phase timer, the sensor and both lamp buses.
module tlc_junction_checker #(
    parameter int TMR_W          = 8,
    parameter int MIN_HOLD_CYC   = 6,
    parameter int MAIN_YEL_CYC   = 3,
    parameter int SIDE_GREEN_CYC = 8,
    parameter int SIDE_YEL_CYC   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             side_sensor,
    input logic [1:0]       phase,
    input logic [TMR_W-1:0] timer_q,
    input logic [2:0]       main_lamp,
    input logic [2:0]       side_lamp
);

    AST_RESET_TO_MAIN: assert property (@(posedge clk)
        !rst_n |=> (phase == 2'd0) && (timer_q == '0)); // R1

    AST_CYCLIC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (phase != $past(phase))) |-> (phase == $past(phase) + 2'd1)); // R2

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (phase != $past(phase))) |-> (timer_q == '0)); // R2

    AST_YELLOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 2'd1) |-> (timer_q < TMR_W'(MAIN_YEL_CYC))) and
        ((phase == 2'd3) |-> (timer_q < TMR_W'(SIDE_YEL_CYC)))); // R3

    AST_SIDE_GREEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2) |-> (timer_q < TMR_W'(SIDE_GREEN_CYC))); // R4

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 2'd0) && (timer_q < TMR_W'(MIN_HOLD_CYC - 1))) |=> (phase == 2'd0)); // R5

    AST_DEMAND_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 2'd0) && side_sensor && (timer_q >= TMR_W'(MIN_HOLD_CYC - 1))) |=> (phase == 2'd1)); // R6

    AST_REST_IN_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 2'd0) && !side_sensor) |=> (phase == 2'd0)); // R7

    AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(main_lamp) == 1) && ($countones(side_lamp) == 1)); // R8

    AST_ONE_ROAD_RED: assert property (@(posedge clk) disable iff (!rst_n)
        main_lamp[0] != side_lamp[0]); // R8

endmodule

bind tlc_junction_ctrl tlc_junction_checker #(
    .TMR_W          (TMR_W),
    .MIN_HOLD_CYC   (MIN_HOLD_CYC),
    .MAIN_YEL_CYC   (MAIN_YEL_CYC),
    .SIDE_GREEN_CYC (SIDE_GREEN_CYC),
    .SIDE_YEL_CYC   (SIDE_YEL_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .side_sensor (side_sensor),
    .phase       (phase),
    .timer_q     (timer_q),
    .main_lamp   (main_lamp),
    .side_lamp   (side_lamp)
);

// File: tb/tlc_junction_ctrl_test.sv
// Bench: directed scenarios for the junction controller with shortened
// durations. Inputs change 1 ns after a rising edge and outputs are sampled there.
module tlc_junction_ctrl_test;

    localparam int MG  = 20;
    localparam int MIN = 6;
    localparam int MY  = 3;
    localparam int SG  = 8;
    localparam int SY  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       side_sensor = 1'b0;
    logic [2:0] main_lamp;
    logic [2:0] side_lamp;
    logic [1:0] phase;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tlc_junction_ctrl #(
        .MAIN_GREEN_CYC (MG),
        .MIN_HOLD_CYC   (MIN),
        .MAIN_YEL_CYC   (MY),
        .SIDE_GREEN_CYC (SG),
        .SIDE_YEL_CYC   (SY)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .side_sensor (side_sensor),
        .main_lamp   (main_lamp),
        .side_lamp   (side_lamp),
        .phase       (phase)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R8 lamp pattern expected for a phase code
    function automatic logic [5:0] lamps_for(input logic [1:0] p);
        case (p)
            2'd0:    return {3'b001, 3'b100};
            2'd1:    return {3'b001, 3'b010};
            2'd2:    return {3'b100, 3'b001};
            default: return {3'b010, 3'b001};
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_lamps();
        check_eq("R8 lamps", int'({side_lamp, main_lamp}), int'(lamps_for(phase)));
    endtask

    // count edges until the phase changes
    task automatic measure(output int n);
        logic [1:0] start;
        start = phase;
        n = 0;
        do begin
            step();
            n++;
        end while (phase == start && n < 1000);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        side_sensor = 1'b1;
        apply_reset();
        check_eq("R1 phase after reset", int'(phase), 0);
        check_eq("R1 main lamp green", int'(main_lamp), 3'b100);
        check_eq("R1 side lamp red", int'(side_lamp), 3'b001);
    endtask

    task automatic t_rest_main();
        side_sensor = 1'b0;
        apply_reset();
        for (int i = 0; i < 3 * MG; i++) step();
        check_eq("R7 main green persists", int'(phase), 0);
        check_lamps();
    endtask

    task automatic t_early_pulse();
        side_sensor = 1'b0;
        apply_reset();
        side_sensor = 1'b1;
        for (int i = 0; i < MIN - 1; i++) step();
        side_sensor = 1'b0;
        check_eq("R5 pulse inside hold ignored", int'(phase), 0);
        for (int i = 0; i < 10; i++) step();
        check_eq("R5 still main green", int'(phase), 0);
        check_lamps();
        side_sensor = 1'b1;
        step();
        check_eq("R6 late demand acts at first edge", int'(phase), 1);
    endtask

    task automatic t_full_cycle(input logic sens_in_side);
        int n;
        side_sensor = 1'b1;
        apply_reset();
        measure(n);
        check_eq("R6 main green length with demand", n, MIN);
        check_eq("R2 after main green", int'(phase), 1);
        check_lamps();
        side_sensor = sens_in_side;
        measure(n);
        check_eq("R3 main yellow length", n, MY);
        check_eq("R2 after main yellow", int'(phase), 2);
        check_lamps();
        measure(n);
        check_eq("R4 side green length", n, SG);
        check_eq("R2 after side green", int'(phase), 3);
        check_lamps();
        measure(n);
        check_eq("R3 side yellow length", n, SY);
        check_eq("R2 wraps to main green", int'(phase), 0);
        check_lamps();
        if (sens_in_side) begin
            measure(n);
            check_eq("R6 second main green length", n, MIN);
        end else begin
            for (int i = 0; i < 2 * MG; i++) step();
            check_eq("R7 rest after wrap", int'(phase), 0);
        end
    endtask

    task automatic t_hold_boundary();
        side_sensor = 1'b0;
        apply_reset();
        for (int i = 0; i < MIN - 1; i++) step();
        side_sensor = 1'b1;
        step();
        check_eq("R6 demand on hold-expiry edge", int'(phase), 1);
        side_sensor = 1'b0;
        apply_reset();
        for (int i = 0; i < MIN - 2; i++) step();
        side_sensor = 1'b1;
        step();
        check_eq("R5 demand one edge early", int'(phase), 0);
        step();
        check_eq("R6 change on following edge", int'(phase), 1);
    endtask

    task automatic t_mid_reset();
        int n;
        side_sensor = 1'b1;
        apply_reset();
        for (int i = 0; i < MIN + MY + 2; i++) step();
        check_eq("R2 reached side green", int'(phase), 2);
        rst_n = 1'b0;
        step();
        check_eq("R1 reset from side green", int'(phase), 0);
        check_lamps();
        rst_n = 1'b1;
        measure(n);
        check_eq("R1 timer cleared by reset", n, MIN);
    endtask

    initial begin
        t_reset();
        t_rest_main();
        t_early_pulse();
        t_full_cycle(1'b1);
        t_full_cycle(1'b0);
        t_hold_boundary();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule